// File: doc/BRIEF.md
# Serial Engine DMA Channel Control Registers

This block holds the software-visible control state for a single DMA channel of a serial engine, either the transmit side or the receive side, chosen by a parameter. Software uses a simple 32-bit write/read bus to set up a transfer. It loads a 64-bit buffer address as two words and, on the transmit side, an attribute bit. It then writes a byte count, and that write launches the transfer. Three interrupt enables are changed only through separate set and clear addresses, so setting or clearing one enable never needs a read-modify-write.

The real data mover is not part of this block. In its place a stub counter moves one byte per clock until it reaches the programmed count. A test input can abort the transfer with a bus error. When the transfer ends, the block records sticky status bits: done, end-of-transfer and bus error. It also reports the bytes actually moved. A single interrupt line is raised whenever a status bit is set and its enable is set.

Top module: `dmach_top`

## Requirements
- R1: After reset, every readable register reads zero and `irq` is low.
- R2: Offset 0x00 holds the lower and offset 0x04 the upper 32 bits of the 64-bit buffer address; both read back what was written.
- R3: Offset 0x10 reads the enable bits (bit 0 done, bit 1 end-of-transfer, bit 2 bus error). Each 1 written to offset 0x14 sets that enable bit, and each 1 written to offset 0x18 clears it. Bits written as 0 keep their value.
- R4: Offset 0x08 bit 0 is the end-of-transfer marker on a transmit channel. On a receive channel, writes to offset 0x08 are ignored and it reads zero.
- R5: Writing the byte count to offset 0x0C starts a transfer, and status bit 8 (busy, offset 0x20) reads 1 from the next cycle.
- R6: A write to offset 0x0C while busy is ignored. The count and the running transfer are unchanged.
- R7: A transfer of N bytes stays busy for N+1 cycles after the count write, then sets done (bit 0). It also sets end-of-transfer (bit 1) if the attribute bit was set. Offset 0x1C then reads N, and a count of 0 completes after one cycle.
- R8: If `errInject` is high in a busy cycle, the transfer stops in that cycle and bus error (bit 2) is set without done. Offset 0x1C keeps the bytes moved before the error.
- R9: Each 1 written to offset 0x24 clears that status bit. Writing all ones clears every status bit.
- R10: Status bits stay set until cleared. `irq` is high exactly when some status bit and its enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe for one cycle |
| busAddr | input | ADDR_W | Byte offset for write and read |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| errInject | input | 1 | Stub bus error injection |
| irq | output | 1 | Combined interrupt |

## Verification
The bench aims at the exact completion cycle. A counter off by one would report busy one cycle too long or too short, and would read a byte count that differs from the programmed one. It rewrites the count while a transfer runs; a design that accepts that write would end at the second count. It starts a zero-length transfer, which a compare-after-increment design would run almost forever. It injects an error mid-transfer and checks the partial count and the absence of done. It also checks that clearing an enable lowers the interrupt while the sticky status remains, which catches a design that clears status along with the enable.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  localparam logic [7:0] OFF_PTR_LO   = 8'h00;
  localparam logic [7:0] OFF_PTR_HI   = 8'h04;
  localparam logic [7:0] OFF_ATTR     = 8'h08;
  localparam logic [7:0] OFF_LEN      = 8'h0C;
  localparam logic [7:0] OFF_IEN      = 8'h10;
  localparam logic [7:0] OFF_IEN_SET  = 8'h14;
  localparam logic [7:0] OFF_IEN_CLR  = 8'h18;
  localparam logic [7:0] OFF_LEN_IN   = 8'h1C;
  localparam logic [7:0] OFF_STAT     = 8'h20;
  localparam logic [7:0] OFF_STAT_CLR = 8'h24;

  localparam int STAT_W   = 3;
  localparam int BIT_DONE = 0;
  localparam int BIT_EOT  = 1;
  localparam int BIT_ERR  = 2;
  localparam int BIT_BUSY = 8;

  typedef struct packed {
    logic wrPtrLo;
    logic wrPtrHi;
    logic wrAttr;
    logic wrLen;
    logic wrIenSet;
    logic wrIenClr;
    logic wrStatClr;
  } strobe_t;

  typedef struct packed {
    logic [63:0]       ptr;
    logic              attrEot;
    logic [31:0]       len;
    logic [31:0]       lenIn;
    logic [STAT_W-1:0] ien;
    logic [STAT_W-1:0] stat;
    logic              busy;
  } view_t;

endpackage

// File: rtl/dmach_ctrl.sv
module dmach_ctrl
  import dmach_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  view_t             view,
  output strobe_t           strb,
  output logic [31:0]       busRdData
);

  always_comb begin
    strb = '0;
    if (busWrEn) begin
      if (busAddr == ADDR_W'(OFF_PTR_LO))   strb.wrPtrLo   = 1'b1;
      if (busAddr == ADDR_W'(OFF_PTR_HI))   strb.wrPtrHi   = 1'b1;
      if (busAddr == ADDR_W'(OFF_ATTR))     strb.wrAttr    = 1'b1;
      if (busAddr == ADDR_W'(OFF_LEN))      strb.wrLen     = 1'b1;
      if (busAddr == ADDR_W'(OFF_IEN_SET))  strb.wrIenSet  = 1'b1;
      if (busAddr == ADDR_W'(OFF_IEN_CLR))  strb.wrIenClr  = 1'b1;
      if (busAddr == ADDR_W'(OFF_STAT_CLR)) strb.wrStatClr = 1'b1;
    end
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_W'(OFF_PTR_LO)) busRdData = view.ptr[31:0];
    if (busAddr == ADDR_W'(OFF_PTR_HI)) busRdData = view.ptr[63:32];
    if (busAddr == ADDR_W'(OFF_ATTR))   busRdData = {31'b0, view.attrEot};
    if (busAddr == ADDR_W'(OFF_LEN))    busRdData = view.len;
    if (busAddr == ADDR_W'(OFF_IEN))    busRdData = {{(32-STAT_W){1'b0}}, view.ien};
    if (busAddr == ADDR_W'(OFF_LEN_IN)) busRdData = view.lenIn;
    if (busAddr == ADDR_W'(OFF_STAT)) begin
      busRdData = {{(32-STAT_W){1'b0}}, view.stat};
      busRdData[BIT_BUSY] = view.busy;
    end
  end

endmodule

// File: rtl/dmach_dpath.sv
module dmach_dpath
  import dmach_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter bit IS_TX = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     strb,
  input  logic [31:0] wrData,
  input  logic        errInject,
  output view_t       view,
  output logic        irq
);

  logic [31:0]       ptrLo, ptrHi;
  logic              attrEot;
  logic [LEN_W-1:0]  lenReg, moved;
  logic [STAT_W-1:0] ien, stat, statNext;
  logic              busy;

  // Registers loaded by plain writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrLo   <= '0;
      ptrHi   <= '0;
      attrEot <= 1'b0;
      ien     <= '0;
    end else begin
      if (strb.wrPtrLo) ptrLo <= wrData;
      if (strb.wrPtrHi) ptrHi <= wrData;
      if (strb.wrAttr && IS_TX) attrEot <= wrData[0];
      if (strb.wrIenSet) ien <= ien | wrData[STAT_W-1:0];
      if (strb.wrIenClr) ien <= ien & ~wrData[STAT_W-1:0];
    end
  end

  // Status: clear first, then completion events override
  always_comb begin
    statNext = stat;
    if (strb.wrStatClr) statNext = statNext & ~wrData[STAT_W-1:0];
    if (busy) begin
      if (errInject) begin
        statNext[BIT_ERR] = 1'b1;
      end else if (moved == lenReg) begin
        statNext[BIT_DONE] = 1'b1;
        if (attrEot) statNext[BIT_EOT] = 1'b1;
      end
    end
  end

  // Stub transfer engine: one byte per busy cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      moved  <= '0;
      lenReg <= '0;
      stat   <= '0;
    end else begin
      stat <= statNext;
      if (busy) begin
        if (errInject || moved == lenReg) busy <= 1'b0;
        else                              moved <= moved + 1'b1;
      end else if (strb.wrLen) begin
        busy   <= 1'b1;
        moved  <= '0;
        lenReg <= wrData[LEN_W-1:0];
      end
    end
  end

  always_comb begin
    view         = '0;
    view.ptr     = {ptrHi, ptrLo};
    view.attrEot = attrEot;
    view.len     = 32'(lenReg);
    view.lenIn   = 32'(moved);
    view.ien     = ien;
    view.stat    = stat;
    view.busy    = busy;
  end

  assign irq = |(stat & ien);

  AST_BUSY_FROM_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(strb.wrLen)); // R5
  AST_LEN_HELD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && strb.wrLen) |=> $stable(lenReg)); // R6
  AST_IEN_SET_BITS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrIenSet |=> ((ien & $past(wrData[STAT_W-1:0])) == $past(wrData[STAT_W-1:0]))); // R3
  AST_DONE_AT_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stat[BIT_DONE]) |-> ($past(busy) && moved == lenReg)); // R7
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stat[BIT_ERR]) |-> !busy); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (stat[BIT_DONE] && !strb.wrStatClr) |=> stat[BIT_DONE]); // R10

endmodule

// File: rtl/dmach_top.sv
module dmach_top
  import dmach_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 16,
  parameter bit IS_TX  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              errInject,
  output logic              irq
);

  strobe_t strb;
  view_t   view;

  dmach_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .view      (view),
    .strb      (strb),
    .busRdData (busRdData)
  );

  dmach_dpath #(.LEN_W(LEN_W), .IS_TX(IS_TX)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (busWrData),
    .errInject (errInject),
    .view      (view),
    .irq       (irq)
  );

endmodule

// File: tb/dmach_top_tb.sv
module dmach_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] rdTx, rdRx;
  logic        errInject = 1'b0;
  logic        irqTx, irqRx;
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  dmach_top #(.IS_TX(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(rdTx), .errInject(errInject), .irq(irqTx));

  dmach_top #(.IS_TX(1'b0)) u_dutRx (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(rdRx), .errInject(1'b0), .irq(irqRx));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a; #1; d = rdTx;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] d;
    for (int a = 0; a <= 8'h24; a += 4) begin
      rd(8'(a), d);
      check("R1 reset read", d, 32'h0);
    end
    check("R1 reset irq", {31'b0, irqTx}, 32'h0);
  endtask

  task automatic testPointer();
    logic [31:0] d;
    wr(8'h00, 32'hDEAD_BEEF);
    wr(8'h04, 32'h0000_1234);
    rd(8'h00, d); check("R2 ptr low", d, 32'hDEAD_BEEF);
    rd(8'h04, d); check("R2 ptr high", d, 32'h0000_1234);
  endtask

  task automatic testIen();
    logic [31:0] d;
    wr(8'h14, 32'h5);
    rd(8'h10, d); check("R3 set 101", d, 32'h5);
    wr(8'h14, 32'h2);
    rd(8'h10, d); check("R3 set adds bit1", d, 32'h7);
    wr(8'h18, 32'h4);
    rd(8'h10, d); check("R3 clear bit2", d, 32'h3);
    wr(8'h14, 32'h7);
  endtask

  task automatic testAttr();
    logic [31:0] d;
    wr(8'h08, 32'h1);
    rd(8'h08, d); check("R4 tx attr", d, 32'h1);
    busAddr = 8'h08; #1;
    check("R4 rx attr ignored", rdRx, 32'h0);
  endtask

  task automatic testTransfer();
    logic [31:0] d;
    wr(8'h0C, 32'd3);
    rd(8'h20, d); check("R5 busy after start", d, 32'h100);
    waitEdges(3);
    rd(8'h20, d); check("R7 still busy at N", d, 32'h100);
    waitEdges(1);
    rd(8'h20, d); check("R7 done+eot", d, 32'h3);
    rd(8'h1C, d); check("R7 bytes moved", d, 32'd3);
    check("R10 irq on done", {31'b0, irqTx}, 32'h1);
  endtask

  task automatic testStatClr();
    logic [31:0] d;
    wr(8'h24, 32'h2);
    rd(8'h20, d); check("R9 clear eot only", d, 32'h1);
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h20, d); check("R9 clear all", d, 32'h0);
    check("R10 irq low after clear", {31'b0, irqTx}, 32'h0);
  endtask

  task automatic testBusyIgnore();
    logic [31:0] d;
    wr(8'h08, 32'h0);
    wr(8'h0C, 32'd5);
    wr(8'h0C, 32'd9);
    waitEdges(5);
    rd(8'h0C, d); check("R6 count kept", d, 32'd5);
    rd(8'h20, d); check("R6 done no eot", d, 32'h1);
    rd(8'h1C, d); check("R6 moved 5", d, 32'd5);
    wr(8'h24, 32'hFFFF_FFFF);
  endtask

  task automatic testZeroLen();
    logic [31:0] d;
    wr(8'h0C, 32'd0);
    waitEdges(1);
    rd(8'h20, d); check("R7 zero length done", d, 32'h1);
    rd(8'h1C, d); check("R7 zero moved", d, 32'd0);
    wr(8'h24, 32'hFFFF_FFFF);
  endtask

  task automatic testError();
    logic [31:0] d;
    wr(8'h0C, 32'd10);
    repeat (2) @(posedge clk);
    @(negedge clk); errInject = 1'b1;
    @(posedge clk);
    @(negedge clk); errInject = 1'b0;
    rd(8'h20, d); check("R8 err no done", d, 32'h4);
    rd(8'h1C, d); check("R8 partial count", d, 32'd2);
  endtask

  task automatic testIrqMask();
    logic [31:0] d;
    wr(8'h18, 32'h4);
    check("R10 irq masked", {31'b0, irqTx}, 32'h0);
    rd(8'h20, d); check("R10 status sticky", d, 32'h4);
    wr(8'h14, 32'h4);
    check("R10 irq unmasked", {31'b0, irqTx}, 32'h1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPointer();
    testIen();
    testAttr();
    testTransfer();
    testStatClr();
    testBusyIgnore();
    testZeroLen();
    testError();
    testIrqMask();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule